// File: doc/BRIEF.md
# Fine-Grain Body Bias Step Controller

This block is the digital loop that steers the body bias of one bias cell. Several timing monitors in the cell each compare a delay-path copy against the clock plus a margin. Each monitor reports either "slow" (the path misses the margin) or "fast" (the path meets it with margin to spare). The controller samples these reports and keeps two bias codes. The codes feed external digital-to-analog converters for the NMOS and PMOS wells.

A single slow monitor pushes the cell toward forward bias. The cell relaxes toward reverse bias only when every monitor reports fast. As a result, the loop settles at the weakest forward bias, or the strongest reverse bias, that still meets timing. It keeps tracking as temperature shifts delay. The two codes always move in opposite directions. Steps are taken at most once per programmable settle interval, so the analog bias has time to stabilise. A lock flag reports that the loop has been quiet for a programmable number of intervals.

Top module: `bias_step_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, both codes hold the midpoint value 2^(CODE_W-1), `locked` is 0 (for `lock_thresh` of at least 1), and the interval timer restarts from zero.
- R2: Every monitor input passes through two register stages before use. A change on an input that is sampled at clock edge k can first alter a code at edge k+2.
- R3: The forward decision is the OR of all `slow_req` bits. A single slow monitor is enough to request a forward step.
- R4: The reverse decision is the AND of all `fast_req` bits. A reverse step is requested only when every monitor reports fast.
- R5: If the forward and reverse decisions are both true at an update, the forward step is taken.
- R6: A forward step raises `nmos_code` by 1 and lowers `pmos_code` by 1. A reverse step lowers `nmos_code` by 1 and raises `pmos_code` by 1.
- R7: Each code saturates independently. A code is never raised when it is at or above `code_max`, and never lowered when it is at or below `code_min`.
- R8: The timer counts up from 0 after reset. An update happens at an edge where the timer value is at least `settle_ivl`, and the timer then returns to 0, so updates are `settle_ivl`+1 cycles apart. The codes do not change at any other edge.
- R9: A quiet counter of LOCK_W bits rises by 1 at each update that has no decision, saturates at all ones, and clears at each update that has a decision. `locked` is 1 whenever this counter is at least `lock_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_req | input | NUM_PTS | Per-monitor slow report (request forward step) |
| fast_req | input | NUM_PTS | Per-monitor fast report (request reverse step) |
| code_min | input | CODE_W | Lower saturation limit for both codes |
| code_max | input | CODE_W | Upper saturation limit for both codes |
| settle_ivl | input | TIMER_W | Update interval minus one, in cycles |
| lock_thresh | input | LOCK_W | Quiet updates needed before `locked` rises |
| nmos_code | output | CODE_W | NMOS bias code to the converter |
| pmos_code | output | CODE_W | PMOS bias code to the converter |
| locked | output | 1 | Loop has been quiet for `lock_thresh` updates |

## Verification
The bench builds the block with NUM_PTS=3, CODE_W=4, TIMER_W=4 and LOCK_W=3. With three monitors, all 64 slow/fast combinations can be swept exhaustively, including every case where the two decisions collide. A 4-bit code reaches its limits within a few intervals, so saturation at both ends is driven repeatedly under several limit pairs. A 3-bit quiet counter lets the run reach the lock counter's own saturation. The sweep also uses several short settle intervals, including zero, so update timing and the two-stage input delay are seen at every phase.

// File: rtl/bias_step_ctrl.sv
module bias_step_ctrl #(
  parameter int NUM_PTS = 8,
  parameter int CODE_W  = 6,
  parameter int TIMER_W = 12,
  parameter int LOCK_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PTS-1:0] slow_req,
  input  logic [NUM_PTS-1:0] fast_req,
  input  logic [CODE_W-1:0]  code_min,
  input  logic [CODE_W-1:0]  code_max,
  input  logic [TIMER_W-1:0] settle_ivl,
  input  logic [LOCK_W-1:0]  lock_thresh,
  output logic [CODE_W-1:0]  nmos_code,
  output logic [CODE_W-1:0]  pmos_code,
  output logic               locked
);
  localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [LOCK_W-1:0] QTOP = '1;

  logic [NUM_PTS-1:0] slow_m, slow_q, fast_m, fast_q;
  logic [TIMER_W-1:0] tmr;
  logic [LOCK_W-1:0]  quiet;
  logic upd_tick, fwd_vote, rev_vote, go_fwd, go_rev;

  assign upd_tick = tmr >= settle_ivl;
  assign fwd_vote = |slow_q;
  assign rev_vote = &fast_q;
  assign go_fwd   = upd_tick & fwd_vote;
  assign go_rev   = upd_tick & rev_vote & ~fwd_vote;
  assign locked   = quiet >= lock_thresh;

  function automatic logic [CODE_W-1:0] bump(input logic [CODE_W-1:0] v,
                                             input logic up, input logic dn,
                                             input logic [CODE_W-1:0] lo,
                                             input logic [CODE_W-1:0] hi);
    if (up && v < hi) return v + 1'b1;
    if (dn && v > lo) return v - 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_m    <= '0;
      slow_q    <= '0;
      fast_m    <= '0;
      fast_q    <= '0;
      tmr       <= '0;
      quiet     <= '0;
      nmos_code <= MID;
      pmos_code <= MID;
    end else begin
      slow_m <= slow_req;
      slow_q <= slow_m;
      fast_m <= fast_req;
      fast_q <= fast_m;
      tmr    <= upd_tick ? '0 : tmr + 1'b1;
      if (upd_tick) begin
        nmos_code <= bump(nmos_code, go_fwd, go_rev, code_min, code_max);
        pmos_code <= bump(pmos_code, go_rev, go_fwd, code_min, code_max);
        if (fwd_vote || rev_vote) quiet <= '0;
        else if (quiet != QTOP)   quiet <= quiet + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bias_step_ctrl_chk.sv
module bias_step_ctrl_chk #(
  parameter int CODE_W = 6,
  parameter int LOCK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] nmos_code,
  input logic [CODE_W-1:0] pmos_code,
  input logic [CODE_W-1:0] code_min,
  input logic [CODE_W-1:0] code_max,
  input logic [LOCK_W-1:0] lock_thresh,
  input logic              locked,
  input logic              upd_tick,
  input logic              fwd_vote,
  input logic              rev_vote
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  p_reset_mid_r1: assert property (@(posedge clk)
    !rst_n |=> (nmos_code == MID && pmos_code == MID));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_tick) |-> ($stable(nmos_code) && $stable(pmos_code)));

  p_fwd_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && fwd_vote && nmos_code < code_max) |=> nmos_code == $past(nmos_code) + 1'b1);

  p_opposite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmos_code > $past(nmos_code)) |-> !(pmos_code > $past(pmos_code)));

  p_no_overshoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmos_code > $past(nmos_code)) |-> nmos_code <= code_max);

  p_no_undershoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pmos_code < $past(pmos_code)) |-> pmos_code >= code_min);

  p_lock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && (fwd_vote || rev_vote) && lock_thresh != '0) |=> !locked);
endmodule

bind bias_step_ctrl bias_step_ctrl_chk #(.CODE_W(CODE_W), .LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmos_code(nmos_code), .pmos_code(pmos_code),
  .code_min(code_min), .code_max(code_max), .lock_thresh(lock_thresh),
  .locked(locked), .upd_tick(upd_tick), .fwd_vote(fwd_vote), .rev_vote(rev_vote));

// File: tb/bias_step_ctrl_bench.sv
module bias_step_ctrl_bench;
  localparam int NP = 3, CW = 4, TW = 4, LW = 3;
  localparam int MIDV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] slow_req = '0, fast_req = '0;
  logic [CW-1:0] code_min = '0, code_max = '1;
  logic [TW-1:0] settle_ivl = '0;
  logic [LW-1:0] lock_thresh = 3'd2;
  logic [CW-1:0] nmos_code, pmos_code;
  logic locked;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bias_step_ctrl #(.NUM_PTS(NP), .CODE_W(CW), .TIMER_W(TW), .LOCK_W(LW)) u_bias_step_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_req(slow_req), .fast_req(fast_req),
    .code_min(code_min), .code_max(code_max), .settle_ivl(settle_ivl),
    .lock_thresh(lock_thresh), .nmos_code(nmos_code), .pmos_code(pmos_code),
    .locked(locked));

  // Requirement-level reference: delayed votes, interval timer, clamped steps.
  int m_s1, m_s2, m_f1, m_f2, m_t, m_n, m_p, m_q, m_kind;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_f1 <= 0; m_f2 <= 0; m_t <= 0;
      m_n <= MIDV; m_p <= MIDV; m_q <= 0; m_kind <= 0;
    end else begin
      bit fw, rv;
      fw = (m_s2 != 0);
      rv = (m_f2 == 7);
      m_s1 <= slow_req; m_s2 <= m_s1; m_f1 <= fast_req; m_f2 <= m_f1;
      if (m_t >= settle_ivl) begin
        m_t <= 0;
        if (fw) begin
          m_kind <= rv ? 3 : 1;
          if (m_n < code_max) m_n <= m_n + 1;
          if (m_p > code_min) m_p <= m_p - 1;
        end else if (rv) begin
          m_kind <= 2;
          if (m_n > code_min) m_n <= m_n - 1;
          if (m_p < code_max) m_p <= m_p + 1;
        end else m_kind <= 0;
        m_q <= (fw || rv) ? 0 : (m_q == 7 ? 7 : m_q + 1);
      end else m_t <= m_t + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model();
    string tg;
    case (m_kind)
      1: tg = "R3 R6 R7";
      2: tg = "R4 R6 R7";
      3: tg = "R5 R3 R4";
      default: tg = "R8 R2";
    endcase
    chk(tg, nmos_code, m_n);
    chk(tg, pmos_code, m_p);
    chk("R9", locked, (m_q >= lock_thresh) ? 1 : 0);
  endtask

  task automatic do_reset(input int s, input int lo, input int hi, input int lt);
    @(negedge clk);
    rst_n = 1'b0; slow_req = '0; fast_req = '0;
    settle_ivl = TW'(s); code_min = CW'(lo); code_max = CW'(hi); lock_thresh = LW'(lt);
    repeat (2) @(negedge clk);
    chk("R1 in reset", nmos_code, MIDV);
    chk("R1 in reset", pmos_code, MIDV);
    chk("R1 in reset", locked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", nmos_code, MIDV);
    chk("R1 after release", pmos_code, MIDV);
  endtask

  initial begin
    // R2 latency and R6 direction, update every cycle
    do_reset(0, 0, 15, 3);
    slow_req = 3'b001;
    @(negedge clk); chk("R2 stage 1", nmos_code, MIDV + 1 - 1);
    @(negedge clk); chk("R2 stage 2", nmos_code, MIDV);
    @(negedge clk); chk("R2 first step", nmos_code, MIDV + 1);
    chk("R6 forward pmos", pmos_code, MIDV - 1);
    slow_req = '0;

    // R7 saturation at both ends
    do_reset(0, 6, 10, 3);
    slow_req = 3'b111;
    repeat (12) @(negedge clk);
    chk("R7 nmos at max", nmos_code, 10);
    chk("R7 pmos at min", pmos_code, 6);
    slow_req = '0; fast_req = 3'b111;
    repeat (12) @(negedge clk);
    chk("R7 nmos at min", nmos_code, 6);
    chk("R7 pmos at max", pmos_code, 10);
    fast_req = 3'b011;
    repeat (6) @(negedge clk);
    chk("R4 partial fast holds", nmos_code, 6);

    // R9 lock rise and clear
    do_reset(1, 0, 15, 3);
    repeat (40) @(negedge clk);
    chk("R9 locked when quiet", locked, 1);
    slow_req = 3'b100;
    repeat (5) @(negedge clk);
    chk("R9 cleared by step", locked, 0);
    slow_req = '0;

    // Exhaustive request sweep under several intervals and limits
    for (int c = 0; c < 4; c++) begin
      int s, lo, hi, lt;
      s  = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 3 : 2;
      lo = (c == 1) ? 6 : (c == 3) ? 8 : 0;
      hi = (c == 1) ? 10 : (c == 3) ? 9 : 15;
      lt = (c == 0) ? 2 : (c == 1) ? 1 : (c == 2) ? 3 : 7;
      do_reset(s, lo, hi, lt);
      for (int pat = 0; pat < 64; pat++) begin
        slow_req = NP'(pat);
        fast_req = NP'(pat >> 3);
        for (int k = 0; k < 2 * (s + 1) + 1; k++) begin
          @(negedge clk);
          chk_model();
        end
      end
      slow_req = '0; fast_req = '0;
      for (int k = 0; k < 10 * (s + 1); k++) begin
        @(negedge clk);
        chk_model();
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule